// File: doc/BRIEF.md
# SONET Receive Framer with Tracking Supervision

This block takes a recovered STS-3/STM-1 line stream at 155.52 Mbit/s, one bit per clock enable, and looks for the frame alignment word at every bit offset. The alignment word is the tail of the A1 run (0xF6 bytes) followed by the head of the A2 run (0x28 bytes). After it finds the word, it cuts the stream into 8-bit bytes or 4-bit nibbles on frame-relative boundaries. It raises a one-cycle word strobe for each word and marks the first word of every frame.

A mode input selects between two kinds of operation. In tracking mode a frame position counter predicts where the next alignment word should end, and the word is compared at that point in every frame. A mismatch gives a frame-error pulse. A run of mismatches declares out-of-frame and restarts the bit-offset search. An out-of-frame condition that lasts long enough escalates to loss-of-frame. In non-tracking mode the block locks once, keeps its alignment without further checks, and holds all three alarm outputs low.

Top module: `sonet_rx_framer`

## Requirements
- R1: From search, the block locks on the first complete alignment window (WIN_A1 bytes of 0xF6 then WIN_A2 bytes of 0x28, MSB first) at any bit offset. The first word it marks with frame_o is frame byte 0, of value 0xF6 (or 0xF, its upper nibble, in nibble mode).
- R2: In byte mode (width_byte_i=1), data_o carries each frame byte with its first-received bit in data_o[7], word_vld_o pulses once per byte, and frame_o is high only with byte 0.
- R3: In nibble mode (width_byte_i=0), each byte comes out as two words, high nibble first, in data_o[3:0] with data_o[7:4]=0, and word_vld_o never stays high on two cycles in a row.
- R4: A change of width_byte_i takes effect at the next frame start, so every frame holds exactly FRAME_BYTES bytes or 2*FRAME_BYTES nibbles.
- R5: In tracking mode, a mismatch at the predicted alignment position produces a one-cycle rfe_o pulse. A single such frame does not assert oof_o.
- R6: MISS_LIMIT (4) consecutive mismatched frames assert oof_o and restart the search. No words are delivered while searching.
- R7: After relock, oof_o stays high until GOOD_LIMIT (2) consecutive frames match at the predicted position. oof_o falls only while locked.
- R8: lof_o rises after LOF_FRAMES (24) frame periods of continuous out-of-frame, and falls after LOF_FRAMES frame periods of continuous in-frame operation.
- R9: With track_i=0, rfe_o, oof_o and lof_o stay low, and corrupted alignment words neither realign nor interrupt the word stream.
- R10: Reset clears lock, all alarms, the counters and the outputs, and restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies bit_i for this cycle |
| bit_i | input | 1 | Serial line bit |
| width_byte_i | input | 1 | 1: byte words, 0: nibble words |
| track_i | input | 1 | 1: tracking supervision, 0: lock once |
| data_o | output | 8 | Output word (nibble in bits 3:0) |
| word_vld_o | output | 1 | One-cycle strobe per output word |
| frame_o | output | 1 | Marks the first word of a frame |
| rfe_o | output | 1 | Frame-error pulse |
| oof_o | output | 1 | Out-of-frame alarm |
| lof_o | output | 1 | Loss-of-frame alarm |

## Verification
The assertions take for granted that a frame boundary falls on a byte boundary and that word boundaries are at least four enabled bits apart. Given that, strobes and frame-error pulses can never sit on adjacent cycles. They also assume that track_i changes only between comparison points. The stimulus builds whole frames of 8*FRAME_BYTES bits with a random bit-offset lead-in and random gaps in bit_en_i. It keeps random payload bytes away from 0xF6 and 0x28, and it changes the mode and width inputs only in the middle of a frame.

// File: rtl/sonet_rx_pkg.sv
package sonet_rx_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_SYNC   = 1'b1
  } rx_state_e;

  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;

  // alignment window, A1 part first, MSB first; n_a1 + n_a2 <= 8
  function automatic logic [63:0] build_pat(input int n_a1, input int n_a2);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < n_a1; i++) p = {p[55:0], A1_BYTE};
    for (int i = 0; i < n_a2; i++) p = {p[55:0], A2_BYTE};
    return p;
  endfunction

endpackage

// File: rtl/rxf_pattern_det.sv
module rxf_pattern_det #(
  parameter int unsigned WIN_BITS = 32,
  parameter logic [WIN_BITS-1:0] PAT = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic hit_o
);

  logic [WIN_BITS-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (bit_en_i) sr_q <= {sr_q[WIN_BITS-3:0], bit_i};
  end

  // window completes with the bit arriving this cycle
  assign hit_o = bit_en_i && ({sr_q, bit_i} == PAT);

endmodule

// File: rtl/rxf_frame_timer.sv
module rxf_frame_timer #(
  parameter int unsigned FRAME_BITS = 19440,
  parameter int unsigned P_END      = 39,
  localparam int unsigned PW        = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          reload_i,
  output logic [PW-1:0] pos_o,
  output logic          check_o,
  output logic          eof_o
);

  localparam logic [PW-1:0] LAST   = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] CHK    = PW'(P_END);
  localparam logic [PW-1:0] RELOAD = PW'((P_END + 1) % FRAME_BITS);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (bit_en_i) begin
      if (reload_i)           pos_q <= RELOAD;
      else if (pos_q == LAST) pos_q <= '0;
      else                    pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o   = pos_q;
  assign check_o = bit_en_i && (pos_q == CHK);
  assign eof_o   = bit_en_i && (pos_q == LAST);

endmodule

// File: rtl/rxf_supervisor.sv
module rxf_supervisor
  import sonet_rx_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 4,
  parameter int unsigned GOOD_LIMIT = 2,
  parameter int unsigned LOF_FRAMES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic check_i,
  input  logic eof_i,
  input  logic track_i,
  output logic sync_o,
  output logic reload_o,
  output logic rfe_o,
  output logic oof_o,
  output logic lof_o
);

  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);
  localparam int unsigned GW = $clog2(GOOD_LIMIT + 1);
  localparam int unsigned LW = $clog2(LOF_FRAMES + 1);
  localparam logic [MW-1:0] MISS_MAX = MW'(MISS_LIMIT - 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(GOOD_LIMIT - 1);
  localparam logic [LW-1:0] LOF_MAX  = LW'(LOF_FRAMES - 1);

  rx_state_e     state_q;
  logic [MW-1:0] miss_q;
  logic [GW-1:0] good_q;
  logic [LW-1:0] lof_cnt_q;
  logic          oof_q, lof_q, rfe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      miss_q  <= '0;
      good_q  <= '0;
      oof_q   <= 1'b0;
      rfe_q   <= 1'b0;
    end else begin
      rfe_q <= 1'b0;
      unique case (state_q)
        ST_SEARCH: begin
          if (hit_i) begin
            state_q <= ST_SYNC;
            miss_q  <= '0;
            good_q  <= '0;
          end
        end
        ST_SYNC: begin
          if (check_i && track_i) begin
            if (hit_i) begin
              miss_q <= '0;
              if (oof_q) begin
                if (good_q == GOOD_MAX) begin
                  oof_q  <= 1'b0;
                  good_q <= '0;
                end else begin
                  good_q <= good_q + 1'b1;
                end
              end
            end else begin
              rfe_q  <= 1'b1;
              good_q <= '0;
              if (miss_q == MISS_MAX) begin
                state_q <= ST_SEARCH;
                oof_q   <= 1'b1;
                miss_q  <= '0;
              end else begin
                miss_q <= miss_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  // lof follows oof after LOF_FRAMES uninterrupted frame periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lof_q     <= 1'b0;
      lof_cnt_q <= '0;
    end else if (oof_q == lof_q) begin
      lof_cnt_q <= '0;
    end else if (eof_i) begin
      if (lof_cnt_q == LOF_MAX) begin
        lof_q     <= oof_q;
        lof_cnt_q <= '0;
      end else begin
        lof_cnt_q <= lof_cnt_q + 1'b1;
      end
    end
  end

  assign sync_o   = (state_q == ST_SYNC);
  assign reload_o = (state_q == ST_SEARCH) && hit_i;
  assign rfe_o    = rfe_q;
  assign oof_o    = oof_q;
  assign lof_o    = lof_q;

endmodule

// File: rtl/rxf_deser.sv
module rxf_deser #(
  parameter int unsigned PW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          bit_i,
  input  logic          sync_i,
  input  logic          eof_i,
  input  logic [PW-1:0] pos_i,
  input  logic          width_byte_i,
  output logic [7:0]    data_o,
  output logic          word_vld_o,
  output logic          frame_o,
  output logic          wide_o
);

  logic [6:0] acc_q;
  logic [7:0] data_q;
  logic       vld_q, frm_q, wide_q;
  logic       bnd, first;
  logic [7:0] word_nxt;

  always_comb begin
    if (wide_q) begin
      bnd      = (pos_i[2:0] == 3'd7);
      first    = (pos_i == PW'(7));
      word_nxt = {acc_q, bit_i};
    end else begin
      bnd      = (pos_i[1:0] == 2'd3);
      first    = (pos_i == PW'(3));
      word_nxt = {4'b0000, acc_q[2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      frm_q  <= 1'b0;
      wide_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
      frm_q <= 1'b0;
      if (bit_en_i) begin
        acc_q <= {acc_q[5:0], bit_i};
        // width only moves between frames or while unlocked
        if (!sync_i || eof_i) wide_q <= width_byte_i;
        if (sync_i && bnd) begin
          data_q <= word_nxt;
          vld_q  <= 1'b1;
          frm_q  <= first;
        end
      end
    end
  end

  assign data_o     = data_q;
  assign word_vld_o = vld_q;
  assign frame_o    = frm_q;
  assign wide_o     = wide_q;

endmodule

// File: rtl/sonet_rx_framer.sv
module sonet_rx_framer #(
  parameter int unsigned FRAME_BYTES = 2430,
  parameter int unsigned A1_BYTES    = 3,
  parameter int unsigned WIN_A1      = 2,
  parameter int unsigned WIN_A2      = 2,
  parameter int unsigned MISS_LIMIT  = 4,
  parameter int unsigned GOOD_LIMIT  = 2,
  parameter int unsigned LOF_FRAMES  = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       bit_i,
  input  logic       width_byte_i,
  input  logic       track_i,
  output logic [7:0] data_o,
  output logic       word_vld_o,
  output logic       frame_o,
  output logic       rfe_o,
  output logic       oof_o,
  output logic       lof_o
);

  localparam int unsigned FRAME_BITS = FRAME_BYTES * 8;
  localparam int unsigned WIN_BITS   = (WIN_A1 + WIN_A2) * 8;
  localparam int unsigned P_END      = (A1_BYTES + WIN_A2) * 8 - 1;
  localparam int unsigned PW         = $clog2(FRAME_BITS);
  localparam logic [WIN_BITS-1:0] PAT =
    WIN_BITS'(sonet_rx_pkg::build_pat(WIN_A1, WIN_A2));

  logic          hit, reload, check, eof, sync;
  logic          oof_raw, lof_raw, wide_cur;
  logic [PW-1:0] pos;

  rxf_pattern_det #(.WIN_BITS(WIN_BITS), .PAT(PAT)) u_det (
    .clk_i, .rst_ni, .bit_en_i, .bit_i, .hit_o(hit)
  );

  rxf_frame_timer #(.FRAME_BITS(FRAME_BITS), .P_END(P_END)) u_timer (
    .clk_i, .rst_ni, .bit_en_i, .reload_i(reload),
    .pos_o(pos), .check_o(check), .eof_o(eof)
  );

  rxf_supervisor #(
    .MISS_LIMIT(MISS_LIMIT), .GOOD_LIMIT(GOOD_LIMIT), .LOF_FRAMES(LOF_FRAMES)
  ) u_sup (
    .clk_i, .rst_ni, .hit_i(hit), .check_i(check), .eof_i(eof),
    .track_i, .sync_o(sync), .reload_o(reload), .rfe_o,
    .oof_o(oof_raw), .lof_o(lof_raw)
  );

  rxf_deser #(.PW(PW)) u_deser (
    .clk_i, .rst_ni, .bit_en_i, .bit_i, .sync_i(sync), .eof_i(eof),
    .pos_i(pos), .width_byte_i, .data_o, .word_vld_o, .frame_o,
    .wide_o(wide_cur)
  );

  assign oof_o = oof_raw & track_i;
  assign lof_o = lof_raw & track_i;

endmodule

// File: rtl/sonet_rx_framer_chk.sv
module sonet_rx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic track_i,
  input logic word_vld_o,
  input logic frame_o,
  input logic rfe_o,
  input logic oof_raw,
  input logic lof_raw,
  input logic sync
);

  p_frame_with_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> word_vld_o);

  p_word_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_rfe_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfe_o |=> !rfe_o);

  p_oof_clear_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oof_raw) |-> sync);

  p_lof_needs_oof_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_raw) |-> oof_raw);

  p_rfe_tracking_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfe_o |-> $past(track_i));

  p_no_words_search_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync && $past(!sync)) |-> !word_vld_o);

endmodule

bind sonet_rx_framer sonet_rx_framer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .track_i(track_i),
  .word_vld_o(word_vld_o), .frame_o(frame_o), .rfe_o(rfe_o),
  .oof_raw(oof_raw), .lof_raw(lof_raw), .sync(sync)
);

// File: tb/sonet_rx_framer_tb.sv
module sonet_rx_framer_tb;

  localparam int FB  = 24;
  localparam int NA1 = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, bit_v = 1'b0, wsel = 1'b1, track = 1'b1;
  logic [7:0] data;
  logic word_vld, frm, rfe, oof, lof;

  int checks = 0, errors = 0;
  int word_cnt = 0, rfe_cnt = 0, frames_seen = 0;
  logic [7:0] payload [FB];

  always #5 clk = ~clk;

  sonet_rx_framer #(.FRAME_BYTES(FB), .A1_BYTES(NA1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .bit_i(bit_v),
    .width_byte_i(wsel), .track_i(track), .data_o(data),
    .word_vld_o(word_vld), .frame_o(frm), .rfe_o(rfe), .oof_o(oof), .lof_o(lof)
  );

  function automatic logic [7:0] exp_byte(input int i);
    if (i < NA1) return 8'hF6;
    if (i < 2 * NA1) return 8'h28;
    return payload[i];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: word stream against frame contents
  bit idx_valid = 0;
  bit cur_w = 1;
  int idx = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rfe) rfe_cnt++;
      if (oof) idx_valid = 0;
      if (word_vld) begin
        word_cnt++;
        if (frm) begin
          if (idx_valid) chk("R4 words per frame", idx + 1, cur_w ? FB : 2 * FB);
          frames_seen++;
          cur_w = wsel;
          idx = 0;
          idx_valid = !oof;
        end else begin
          idx++;
        end
        if (idx_valid) begin
          int bi;
          logic [7:0] e;
          bi = cur_w ? idx : idx / 2;
          e  = exp_byte(bi);
          if (!cur_w) e = (idx % 2 == 0) ? {4'h0, e[7:4]} : {4'h0, e[3:0]};
          if (bi != NA1 - 1) chk(cur_w ? "R2 byte data" : "R3 nibble data", data, e);
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    if ($urandom_range(7) == 0) begin
      bit_en = 1'b0;
      @(posedge clk); #1;
    end
    bit_en = 1'b1;
    bit_v  = b;
    @(posedge clk); #1;
    bit_en = 1'b0;
  endtask

  task automatic send_frame(input bit bad, input int flip_at, input logic new_w);
    for (int b = 0; b < FB; b++) begin
      logic [7:0] v;
      v = exp_byte(b);
      if (bad && b == NA1 - 1) v = 8'h00;
      if (b == flip_at) wsel = new_w;
      for (int k = 7; k >= 0; k--) send_bit(v[k]);
    end
  endtask

  task automatic frames(input int n, input bit bad);
    for (int i = 0; i < n; i++) send_frame(bad, -1, wsel);
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) send_bit(1'($urandom_range(1)));
  endtask

  initial begin
    int r0, w0, f0;
    void'($urandom(32'h5EED_2302));
    for (int i = 0; i < FB; i++) begin
      logic [7:0] v;
      do v = 8'($urandom_range(255)); while (v == 8'hF6 || v == 8'h28);
      payload[i] = v;
    end
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 reset word_vld", word_vld, 0);
    chk("R10 reset oof", oof, 0);
    chk("R10 reset lof", lof, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 acquisition at a random bit offset, R2 byte mode
    junk($urandom_range(60, 5));
    frames(3, 0);
    chk("R1 frames marked after lock", int'(frames_seen >= 2), 1);

    // R4/R3 width change mid-frame
    send_frame(0, 10, 1'b0);
    frames(3, 0);
    send_frame(0, 7, 1'b1);
    frames(2, 0);
    chk("R3 nibble frames seen", int'(frames_seen >= 7), 1);

    // R5 single error
    r0 = rfe_cnt;
    frames(1, 1);
    frames(1, 0);
    chk("R5 rfe pulses", rfe_cnt - r0, 1);
    chk("R5 no oof", oof, 0);

    // R6 out-of-frame, R8 loss-of-frame, R7 recovery
    frames(3, 1);
    chk("R6 oof after 3 misses", oof, 0);
    frames(1, 1);
    chk("R6 oof after 4 misses", oof, 1);
    w0 = word_cnt;
    frames(2, 1);
    chk("R6 no words while searching", word_cnt - w0, 0);
    frames(18, 1);
    chk("R8 lof before limit", lof, 0);
    frames(4, 1);
    chk("R8 lof after limit", lof, 1);
    frames(2, 0);
    chk("R7 oof held after relock", oof, 1);
    frames(1, 0);
    chk("R7 oof cleared", oof, 0);
    frames(17, 0);
    chk("R8 lof held", lof, 1);
    frames(10, 0);
    chk("R8 lof cleared", lof, 0);

    // R9 non-tracking
    track = 1'b0;
    r0 = rfe_cnt;
    f0 = frames_seen;
    for (int i = 0; i < 6; i++) begin
      frames(1, 1);
      chk("R9 oof low", oof, 0);
      chk("R9 lof low", lof, 0);
    end
    frames(2, 0);
    chk("R9 no rfe", rfe_cnt - r0, 0);
    chk("R9 stream kept", frames_seen - f0, 8);

    // R10 reset mid-run
    track = 1'b1;
    frames(4, 1);
    chk("R10 oof before reset", oof, 1);
    rst_ni = 1'b0;
    @(posedge clk); #1;
    chk("R10 oof cleared", oof, 0);
    chk("R10 rfe cleared", rfe, 0);
    rst_ni = 1'b1;
    w0 = word_cnt;
    junk(50);
    chk("R10 search restarted", word_cnt - w0, 0);
    f0 = frames_seen;
    frames(3, 0);
    chk("R10 relock", int'(frames_seen - f0 >= 2), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule